// File: doc/BRIEF.md
# PIPE Power State Controller

This block sits on the command and status side of a PCI Express PHY interface, clocked by the parallel interface clock. The MAC gives it a 2-bit power-down request, a transmit electrical-idle request and a receiver-detect/loopback request. From these it drives the SerDes controls: power-off, transmit electrical idle, a receiver-detect start pulse and loopback enable. It reports back through a one-cycle PhyStatus pulse and a 3-bit RxStatus code.

Only two power states are implemented: P0, which is normal operation, and P1, in which the PHY is powered off. Requests for P0s or P2 are dropped. A change of power state takes a fixed settle time before PhyStatus confirms it. The receiver-detect request has two meanings. In P1 it starts a detection, which finishes when the analog circuit raises a done input. In P0 it enables loopback. The analog receiver-detect circuit is outside the block and is modelled by a done input and a present input.

Top module: `pipe_pwr_ctrl`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and from the moment it is asserted without waiting for a clock, the block is in P1. In that state serdes_pwr_off=1, serdes_tx_idle=1, phy_status=0, rx_status=000, det_start=0 and loopback_en=0.
- R2: In P1, pwr_req=2'b00 (P0) is accepted at a clock edge. serdes_pwr_off falls in the cycle after acceptance. phy_status pulses exactly SETTLE (16) edges after the accepting edge, and not before.
- R3: In P0, pwr_req=2'b10 (P1) is accepted at a clock edge. serdes_pwr_off rises in the cycle after acceptance. phy_status pulses exactly SETTLE edges after the accepting edge.
- R4: pwr_req=2'b01 (P0s) and 2'b11 (P2) are ignored in both P0 and P1. There is no phy_status pulse and serdes_pwr_off does not change.
- R5: phy_status is high for exactly one clock cycle per completion.
- R6: In P1 with no power change requested, tx_detect_req=1 starts a detection. det_start is high for exactly one cycle, in the cycle after acceptance, and serdes_pwr_off stays 1.
- R7: At the edge where det_done=1 during a detection, phy_status pulses in the following cycle. In that same cycle rx_status=3'b011 if det_present=1, or 3'b000 if det_present=0. At all other times rx_status=3'b000, and det_done outside a detection has no effect.
- R8: While a detection is running, further detect requests produce no det_start, and power requests are not acted on until the completion pulse.
- R9: In P0, loopback_en equals tx_detect_req from the previous edge. In P0 there is no det_start and no phy_status. loopback_en is 0 in the cycle after a P1 request is accepted, and at all times while the PHY is powered off.
- R10: serdes_tx_idle equals tx_idle_req from the previous edge while powered on, and is forced to 1 while serdes_pwr_off=1.
- R11: While a power change is settling, tx_detect_req produces neither det_start nor loopback_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_req | input | 2 | Requested power state: 00 P0, 01 P0s, 10 P1, 11 P2 |
| tx_idle_req | input | 1 | MAC request for transmit electrical idle |
| tx_detect_req | input | 1 | Receiver detect in P1, loopback in P0 |
| det_done | input | 1 | Analog receiver detect finished |
| det_present | input | 1 | Analog receiver detect result, valid with det_done |
| serdes_pwr_off | output | 1 | SerDes powered off |
| serdes_tx_idle | output | 1 | SerDes transmitter held in electrical idle |
| det_start | output | 1 | One-cycle pulse that starts the analog detection |
| loopback_en | output | 1 | SerDes loopback enable |
| phy_status | output | 1 | One-cycle completion pulse |
| rx_status | output | 3 | Receiver detect code: 011 found, 000 otherwise |

## Verification
The bound checker watches these properties on every cycle:
- PhyStatus and det_start are single-cycle pulses.
- rx_status is non-zero only as 011 together with PhyStatus.
- Loopback is never on while the PHY is powered off, and the transmitter is always idle while it is powered off.
- An unsupported request in a steady state changes nothing.
- Every settle lasts exactly SETTLE cycles.

The exact cycle of each PhyStatus pulse, the result code of each detection and the dropping of repeated or mistimed requests come only from the bench's scenarios. The same is true of the one-cycle follow of loopback and idle under random stimulus, and of the immediate effect of an asynchronous reset.

// File: rtl/pipe_pwr_pkg.sv
package pipe_pwr_pkg;

  typedef enum logic [2:0] {
    PS_P1   = 3'd0,
    PS_UP   = 3'd1,
    PS_P0   = 3'd2,
    PS_DOWN = 3'd3,
    PS_DET  = 3'd4
  } pstate_e;

  localparam logic [1:0] PD_P0  = 2'b00;
  localparam logic [1:0] PD_P0S = 2'b01;
  localparam logic [1:0] PD_P1  = 2'b10;
  localparam logic [1:0] PD_P2  = 2'b11;

  localparam logic [2:0] RXS_NONE  = 3'b000;
  localparam logic [2:0] RXS_FOUND = 3'b011;

  // Result code reported with the detect completion pulse
  function automatic logic [2:0] det_code(input logic present);
    return present ? RXS_FOUND : RXS_NONE;
  endfunction

  function automatic logic pd_supported(input logic [1:0] pd);
    return (pd == PD_P0) || (pd == PD_P1);
  endfunction

  // PHY powered when in P0 or ramping up to it
  function automatic logic state_powered(input pstate_e st);
    return (st == PS_P0) || (st == PS_UP);
  endfunction

endpackage

// File: rtl/pipe_cmd_decode.sv
module pipe_cmd_decode
  import pipe_pwr_pkg::*;
(
  input  logic [1:0] pwr_req,
  output logic       want_p0,
  output logic       want_p1,
  output logic       unsupported
);
  assign want_p0     = (pwr_req == PD_P0);
  assign want_p1     = (pwr_req == PD_P1);
  assign unsupported = !pd_supported(pwr_req);
endmodule

// File: rtl/pipe_settle_timer.sv
module pipe_settle_timer #(
  parameter int SETTLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;
  logic          running;

  assign done = running && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (done) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pipe_pwr_fsm.sv
module pipe_pwr_fsm
  import pipe_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want_p0,
  input  logic       want_p1,
  input  logic       tx_detect_req,
  input  logic       det_done,
  input  logic       det_present,
  input  logic       settle_done,
  output pstate_e    state,
  output logic       settle_start,
  output logic       settle_end,
  output logic       det_finish,
  output logic       phy_status,
  output logic [2:0] rx_status,
  output logic       det_start
);
  pstate_e state_nx;
  logic    det_accept;

  always_comb begin
    state_nx     = state;
    settle_start = 1'b0;
    det_accept   = 1'b0;
    unique case (state)
      PS_P1: begin
        if (want_p0) begin
          state_nx     = PS_UP;
          settle_start = 1'b1;
        end else if (tx_detect_req) begin
          state_nx   = PS_DET;
          det_accept = 1'b1;
        end
      end
      PS_UP:   if (settle_done) state_nx = PS_P0;
      PS_P0: begin
        if (want_p1) begin
          state_nx     = PS_DOWN;
          settle_start = 1'b1;
        end
      end
      PS_DOWN: if (settle_done) state_nx = PS_P1;
      PS_DET:  if (det_done) state_nx = PS_P1;
      default: state_nx = PS_P1;
    endcase
  end

  assign settle_end = settle_done && ((state == PS_UP) || (state == PS_DOWN));
  assign det_finish = (state == PS_DET) && det_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PS_P1;
      phy_status <= 1'b0;
      rx_status  <= RXS_NONE;
      det_start  <= 1'b0;
    end else begin
      state      <= state_nx;
      phy_status <= settle_end || det_finish;
      rx_status  <= det_finish ? det_code(det_present) : RXS_NONE;
      det_start  <= det_accept;
    end
  end
endmodule

// File: rtl/pipe_pwr_ctrl.sv
module pipe_pwr_ctrl
  import pipe_pwr_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_req,
  input  logic       tx_idle_req,
  input  logic       tx_detect_req,
  input  logic       det_done,
  input  logic       det_present,
  output logic       serdes_pwr_off,
  output logic       serdes_tx_idle,
  output logic       det_start,
  output logic       loopback_en,
  output logic       phy_status,
  output logic [2:0] rx_status
);
  logic    want_p0, want_p1, pd_unsup;
  logic    settle_done, evt_settle_start, evt_settle_end, evt_det_finish;
  pstate_e state;
  logic    st_p0, st_p1;
  logic    loop_q, idle_q;

  pipe_cmd_decode u_dec (
    .pwr_req     (pwr_req),
    .want_p0     (want_p0),
    .want_p1     (want_p1),
    .unsupported (pd_unsup)
  );

  pipe_settle_timer #(.SETTLE(SETTLE)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (evt_settle_start),
    .done  (settle_done)
  );

  pipe_pwr_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .want_p0       (want_p0),
    .want_p1       (want_p1),
    .tx_detect_req (tx_detect_req),
    .det_done      (det_done),
    .det_present   (det_present),
    .settle_done   (settle_done),
    .state         (state),
    .settle_start  (evt_settle_start),
    .settle_end    (evt_settle_end),
    .det_finish    (evt_det_finish),
    .phy_status    (phy_status),
    .rx_status     (rx_status),
    .det_start     (det_start)
  );

  assign st_p0 = (state == PS_P0);
  assign st_p1 = (state == PS_P1);

  // Loopback only while steadily in P0; cleared as soon as P1 is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      loop_q <= st_p0 && !want_p1 && tx_detect_req;
      idle_q <= tx_idle_req;
    end
  end

  assign serdes_pwr_off = !state_powered(state);
  assign serdes_tx_idle = idle_q || serdes_pwr_off;
  assign loopback_en    = loop_q;
endmodule

// File: rtl/pipe_pwr_ctrl_chk.sv
module pipe_pwr_ctrl_chk #(
  parameter int SETTLE = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       serdes_pwr_off,
  input logic       serdes_tx_idle,
  input logic       det_start,
  input logic       loopback_en,
  input logic       phy_status,
  input logic [2:0] rx_status,
  input logic       pd_unsup,
  input logic       st_p0,
  input logic       st_p1,
  input logic       evt_settle_start,
  input logic       evt_settle_end
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] win;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                win <= '0;
    else if (evt_settle_start) win <= '0;
    else                       win <= win + 1'b1;
  end

  a_r5_phystatus_single: assert property (@(posedge clk) disable iff (!rst_n)
    phy_status |=> !phy_status);

  a_r7_rxstatus_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_status != 3'b000) |-> (phy_status && rx_status == 3'b011));

  a_r6_det_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    det_start |=> !det_start);

  a_r6_det_start_off: assert property (@(posedge clk) disable iff (!rst_n)
    det_start |-> serdes_pwr_off);

  a_r9_loopback_powered: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_en |-> !serdes_pwr_off);

  a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    serdes_pwr_off |-> serdes_tx_idle);

  a_r4_unsupported_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_unsup && (st_p0 || st_p1)) |=> ($stable(serdes_pwr_off) && !phy_status));

  a_r2_settle_length: assert property (@(posedge clk) disable iff (!rst_n)
    evt_settle_end |-> (win == CW'(SETTLE - 1)));
endmodule

bind pipe_pwr_ctrl pipe_pwr_ctrl_chk #(.SETTLE(SETTLE)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .serdes_pwr_off   (serdes_pwr_off),
  .serdes_tx_idle   (serdes_tx_idle),
  .det_start        (det_start),
  .loopback_en      (loopback_en),
  .phy_status       (phy_status),
  .rx_status        (rx_status),
  .pd_unsup         (pd_unsup),
  .st_p0            (st_p0),
  .st_p1            (st_p1),
  .evt_settle_start (evt_settle_start),
  .evt_settle_end   (evt_settle_end)
);

// File: tb/pipe_pwr_ctrl_tb.sv
module pipe_pwr_ctrl_tb;
  localparam int SETTLE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwr_req = 2'b10;
  logic       tx_idle_req = 1'b0, tx_detect_req = 1'b0;
  logic       det_done = 1'b0, det_present = 1'b0;
  logic       serdes_pwr_off, serdes_tx_idle, det_start, loopback_en, phy_status;
  logic [2:0] rx_status;

  int errs = 0;
  int total = 0;

  always #10 clk = ~clk;

  pipe_pwr_ctrl #(.SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .tx_idle_req(tx_idle_req),
    .tx_detect_req(tx_detect_req), .det_done(det_done), .det_present(det_present),
    .serdes_pwr_off(serdes_pwr_off), .serdes_tx_idle(serdes_tx_idle),
    .det_start(det_start), .loopback_en(loopback_en), .phy_status(phy_status),
    .rx_status(rx_status)
  );

  function automatic logic [2:0] exp_rx(input logic present);
    if (present) return 3'b011;
    return 3'b000;
  endfunction

  function automatic logic [1:0] rand_p0_side();
    case ($urandom_range(0, 2))
      0:       return 2'b00;
      1:       return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nclk();
    @(negedge clk);
  endtask

  // Called after the acceptance cycle has been sampled
  task automatic settle(input string tag, input logic exp_off);
    for (int i = 1; i < SETTLE; i++) begin
      nclk();
      chk({tag, " no early phy_status"}, phy_status, 0);
      chk("R11 no det_start while settling", det_start, 0);
      chk("R11 no loopback while settling", loopback_en, 0);
      chk({tag, " power during settle"}, serdes_pwr_off, exp_off);
    end
    tx_detect_req = 1'b0;
    nclk();
    chk({tag, " phy_status at settle end"}, phy_status, 1);
    nclk();
    chk("R5 phy_status one cycle", phy_status, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) nclk();
    chk("R1 reset pwr_off", serdes_pwr_off, 1);
    chk("R1 reset tx_idle", serdes_tx_idle, 1);
    chk("R1 reset phy_status", phy_status, 0);
    chk("R1 reset rx_status", rx_status, 0);
    chk("R1 reset det_start", det_start, 0);
    chk("R1 reset loopback", loopback_en, 0);
    rst_n = 1'b1;
    nclk();
    chk("R1 stays in P1", serdes_pwr_off, 1);

    // Unsupported requests in P1
    for (int i = 0; i < 8; i++) begin
      pwr_req = ($urandom_range(0, 1) != 0) ? 2'b01 : 2'b11;
      nclk();
      chk("R4 P1 unsupported pwr_off", serdes_pwr_off, 1);
      chk("R4 P1 unsupported phy_status", phy_status, 0);
    end

    // P1 -> P0
    pwr_req = 2'b00;
    nclk();
    chk("R2 pwr_off falls", serdes_pwr_off, 0);
    chk("R2 no immediate phy_status", phy_status, 0);
    settle("R2", 1'b0);

    // Random traffic in P0
    for (int i = 0; i < 60; i++) begin
      logic d, t;
      d = 1'($urandom_range(0, 1));
      t = 1'($urandom_range(0, 1));
      pwr_req = rand_p0_side();
      tx_detect_req = d;
      tx_idle_req = t;
      nclk();
      chk("R9 loopback follows request", loopback_en, d);
      chk("R10 tx_idle follows request", serdes_tx_idle, t);
      chk("R9 no det_start in P0", det_start, 0);
      chk("R4 P0 no phy_status", phy_status, 0);
      chk("R4 P0 stays powered", serdes_pwr_off, 0);
    end

    // P0 -> P1 with loopback request held during the change
    pwr_req = 2'b10;
    tx_detect_req = 1'b1;
    tx_idle_req = 1'b0;
    nclk();
    chk("R3 pwr_off rises", serdes_pwr_off, 1);
    chk("R9 loopback cleared on P1 accept", loopback_en, 0);
    chk("R10 tx_idle forced while off", serdes_tx_idle, 1);
    settle("R3", 1'b1);

    // Receiver detection rounds
    for (int k = 0; k < 6; k++) begin
      logic pres;
      int   wt;
      pres = 1'($urandom_range(0, 1));
      wt = $urandom_range(1, 4);
      pwr_req = 2'b10;
      tx_detect_req = 1'b1;
      nclk();
      chk("R6 det_start pulse", det_start, 1);
      chk("R6 stays powered off", serdes_pwr_off, 1);
      pwr_req = 2'b00;
      nclk();
      chk("R8 repeated request no det_start", det_start, 0);
      for (int w = 0; w < wt; w++) begin
        nclk();
        chk("R8 no det_start while running", det_start, 0);
        chk("R8 power request held off", serdes_pwr_off, 1);
        chk("R8 no phy_status while running", phy_status, 0);
      end
      tx_detect_req = 1'b0;
      pwr_req = 2'b10;
      det_done = 1'b1;
      det_present = pres;
      nclk();
      det_done = 1'b0;
      chk("R7 phy_status on detect done", phy_status, 1);
      chk("R7 rx_status result", rx_status, exp_rx(pres));
      nclk();
      chk("R5 detect phy_status one cycle", phy_status, 0);
      chk("R7 rx_status back to 000", rx_status, 0);
    end

    // det_done outside a detection
    det_done = 1'b1;
    det_present = 1'b1;
    nclk();
    det_done = 1'b0;
    chk("R7 stray det_done no phy_status", phy_status, 0);
    chk("R7 stray det_done rx_status", rx_status, 0);

    // Back to P0, then asynchronous reset without a clock edge
    pwr_req = 2'b00;
    nclk();
    chk("R2 second P0 pwr_off", serdes_pwr_off, 0);
    settle("R2", 1'b0);
    #5;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset pwr_off", serdes_pwr_off, 1);
    chk("R1 async reset loopback", loopback_en, 0);
    nclk();
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule